// File: doc/BRIEF.md
# Two-Sided I2C Connection Sequencer

This controller decides when the two halves of a buffered I2C segment, side A and side B, may be tied together. The analog buffers, comparators and pull-up current sources sit outside it. Only digital results arrive here: the sampled SDA and SCL levels of each side, a supply-good flag, an enable, a strap that turns the edge accelerators off, and the level of the output-side supply comparator. The block drives the join command for the data and clock paths, a READY flag, the precharge enable and the accelerator enable.

The block starts in lockout. In lockout the bus levels are ignored and only precharge is active. Once the supply is good and the block is enabled, it watches both sides. It joins them only when each side is free at the same moment. A side is free after a STOP or after a long enough idle time, and the two sides may be free for different reasons. When the output-side supply crosses its threshold in either direction, the join and the accelerators are dropped at once. The bus is then ignored for a blanking window, and both sides must qualify again before the join returns.

Top module: `i2c_join_seq`

## Requirements
- R1: While `pwr_good` is low the block is in lockout. The cycle after `pwr_good` is seen low, `link_on`, `ready` and `accel_en` are 0 and `precharge_en` is 1, whatever the bus levels. A drop of `pwr_good` from any state returns the block to lockout.
- R2: While `enable` is low, no join is made. The cycle after `enable` is seen low, `link_on` and `ready` are 0 and `precharge_en` is 1, and any earlier qualification of either side is discarded.
- R3: A side qualifies on a STOP. A STOP is a rising edge of its synchronized SDA while its synchronized SCL was already high on the previous sample. SDA and SCL rising in the same sample is not a STOP. The qualification is lost as soon as either line of that side is low.
- R4: A side also qualifies when its SDA and SCL are both high for `IDLE_CYCLES` consecutive clock cycles.
- R5: A join is made only when both sides are qualified in the same cycle. The mix of STOP and idle does not matter. A STOP on one side alone never causes a join.
- R6: While joined, `link_on` and `ready` are 1 and `precharge_en` is 0.
- R7: `accel_en` is 1 only while joined and `acc_off` is low. `acc_off` high forces it to 0.
- R8: Outside lockout, a change of the synchronized `out_supply_hi` level in either direction drops `link_on`, `ready`, `accel_en` and `precharge_en` to 0. These outputs stay at 0 for a blanking window of `BLANK_CYCLES` cycles, and bus activity in that window is ignored. A new change during the window restarts it.
- R9: After blanking ends, both sides must qualify again from scratch. A STOP or an idle run seen during the window does not count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwr_good | input | 1 | Primary supply above its lockout threshold |
| enable | input | 1 | Allows the block to join the sides |
| acc_off | input | 1 | High keeps the edge accelerators off |
| out_supply_hi | input | 1 | Output-side supply comparator level, asynchronous |
| a_sda | input | 1 | Side A data level, asynchronous |
| a_scl | input | 1 | Side A clock level, asynchronous |
| b_sda | input | 1 | Side B data level, asynchronous |
| b_scl | input | 1 | Side B clock level, asynchronous |
| link_on | output | 1 | Closes both the SDA and SCL paths between the sides |
| ready | output | 1 | Sides are joined |
| precharge_en | output | 1 | Precharge of the bus pins is active |
| accel_en | output | 1 | Rising-edge accelerators are active |

## Verification
A qualification flag left set when it should be clear shows up as an early join. That join appears a few cycles after the second side goes free, or right after enable returns or blanking ends, instead of a full idle time later. A sequencer stuck in its blanking or lockout state shows up as a join that never returns, which is visible once the blanking time plus an idle time has passed. A missed threshold crossing leaves `link_on` high two synchronizer cycles after the crossing, where it should already be low. A wrong accelerator gate shows on `accel_en` in the very cycle `acc_off` changes.

// File: rtl/i2cj_pkg.sv
`timescale 1ns/1ps
package i2cj_pkg;
   localparam int unsigned SIDES = 2;
   typedef enum logic [1:0] {
      ST_LOCK   = 2'd0,
      ST_WATCH  = 2'd1,
      ST_JOINED = 2'd2,
      ST_BLANK  = 2'd3
   } join_state_t;
endpackage

// File: rtl/i2cj_sync.sv
`timescale 1ns/1ps
module i2cj_sync #(
   parameter int unsigned WIDTH  = 1,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("i2cj_sync: STAGES must be at least 2");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("i2cj_sync: WIDTH must be at least 1");
      end
   endgenerate

   logic [STAGES-1:0][WIDTH-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/i2cj_side_watch.sv
`timescale 1ns/1ps
module i2cj_side_watch #(
   parameter int unsigned IDLE_CYCLES = 6250
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hold,
   input  logic sda,
   input  logic scl,
   output logic qual
);
   localparam int unsigned CW = $clog2(IDLE_CYCLES + 1);
   localparam logic [CW-1:0] CNT_MAX  = CW'(IDLE_CYCLES);
   localparam logic [CW-1:0] CNT_LAST = CW'(IDLE_CYCLES - 1);

   generate
      if (IDLE_CYCLES < 2) begin : g_bad_idle
         $error("i2cj_side_watch: IDLE_CYCLES must be at least 2");
      end
   endgenerate

   logic          sda_q, scl_q;
   logic [CW-1:0] run_cnt;
   logic          stop_seen;

   // rising SDA while SCL was already high on the previous sample
   assign stop_seen = sda && !sda_q && scl && scl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sda_q   <= 1'b0;
         scl_q   <= 1'b0;
         run_cnt <= '0;
         qual    <= 1'b0;
      end else begin
         sda_q <= sda;
         scl_q <= scl;
         if (hold || !sda || !scl) begin
            run_cnt <= '0;
            qual    <= 1'b0;
         end else begin
            if (run_cnt != CNT_MAX) run_cnt <= run_cnt + 1'b1;
            if (stop_seen || run_cnt == CNT_LAST) qual <= 1'b1;
         end
      end
   end

   AST_IDLE_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      run_cnt <= CNT_MAX); // R4
   AST_QUAL_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      (!sda || !scl) |=> !qual); // R3
   AST_HOLD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      hold |=> !qual); // R9
endmodule

// File: rtl/i2cj_blank_timer.sv
`timescale 1ns/1ps
module i2cj_blank_timer #(
   parameter int unsigned BLANK_CYCLES = 11875
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy
);
   localparam int unsigned BW = $clog2(BLANK_CYCLES + 1);
   localparam logic [BW-1:0] LOAD_VAL = BW'(BLANK_CYCLES);

   generate
      if (BLANK_CYCLES < 1) begin : g_bad_blank
         $error("i2cj_blank_timer: BLANK_CYCLES must be at least 1");
      end
   endgenerate

   logic [BW-1:0] remain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              remain <= '0;
      else if (start)          remain <= LOAD_VAL;
      else if (remain != '0)   remain <= remain - 1'b1;
   end

   assign busy = (remain != '0);

   AST_BLANK_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> busy); // R8
   AST_BLANK_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      remain <= LOAD_VAL); // R8
endmodule

// File: rtl/i2c_join_seq.sv
`timescale 1ns/1ps
module i2c_join_seq #(
   parameter int unsigned IDLE_CYCLES  = 6250,
   parameter int unsigned BLANK_CYCLES = 11875,
   parameter int unsigned SYNC_STAGES  = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pwr_good,
   input  logic enable,
   input  logic acc_off,
   input  logic out_supply_hi,
   input  logic a_sda,
   input  logic a_scl,
   input  logic b_sda,
   input  logic b_scl,
   output logic link_on,
   output logic ready,
   output logic precharge_en,
   output logic accel_en
);
   import i2cj_pkg::*;

   localparam int unsigned SYNC_W  = 2 * SIDES + 1;
   localparam int unsigned SUP_BIT = 2 * SIDES;

   logic [SYNC_W-1:0] raw_in, sync_out;
   logic              sup_s, sup_prev, crossing;
   logic [SIDES-1:0]  qual;
   logic              side_hold, blank_start, blank_busy;
   join_state_t       state, state_nx;

   assign raw_in = {out_supply_hi, b_scl, b_sda, a_scl, a_sda};

   i2cj_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(raw_in), .q(sync_out)
   );

   assign sup_s = sync_out[SUP_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sup_prev <= 1'b0;
      else        sup_prev <= sup_s;
   end

   assign crossing  = (sup_s != sup_prev);
   assign side_hold = (state != ST_WATCH) || !enable;

   generate
      for (genvar s = 0; s < SIDES; s++) begin : g_side
         i2cj_side_watch #(.IDLE_CYCLES(IDLE_CYCLES)) u_watch (
            .clk  (clk),
            .rst_n(rst_n),
            .hold (side_hold),
            .sda  (sync_out[2*s]),
            .scl  (sync_out[2*s+1]),
            .qual (qual[s])
         );
      end
   endgenerate

   assign blank_start = pwr_good && (state != ST_LOCK) && crossing;

   i2cj_blank_timer #(.BLANK_CYCLES(BLANK_CYCLES)) u_blank (
      .clk(clk), .rst_n(rst_n), .start(blank_start), .busy(blank_busy)
   );

   always_comb begin
      state_nx = state;
      if (!pwr_good) begin
         state_nx = ST_LOCK;
      end else begin
         unique case (state)
            ST_LOCK:   state_nx = ST_WATCH;
            ST_WATCH:  if (crossing)             state_nx = ST_BLANK;
                       else if (enable && &qual) state_nx = ST_JOINED;
            ST_JOINED: if (crossing)             state_nx = ST_BLANK;
                       else if (!enable)         state_nx = ST_WATCH;
            ST_BLANK:  if (!crossing && !blank_busy) state_nx = ST_WATCH;
            default:   state_nx = ST_LOCK;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= ST_LOCK;
      else        state <= state_nx;
   end

   assign link_on      = (state == ST_JOINED);
   assign ready        = (state == ST_JOINED);
   assign precharge_en = (state == ST_LOCK) || (state == ST_WATCH);
   assign accel_en     = (state == ST_JOINED) && !acc_off;

   AST_LOCK_SAFE: assert property (@(posedge clk) disable iff (!rst_n)
      !pwr_good |=> (!link_on && !accel_en && precharge_en)); // R1
   AST_ENABLE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> (!link_on && !ready)); // R2
   AST_BOTH_SIDES: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(link_on) |-> $past(&qual)); // R5
   AST_JOIN_OUTPUTS: assert property (@(posedge clk) disable iff (!rst_n)
      link_on |-> (ready && !precharge_en)); // R6
   AST_ACCEL_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      accel_en |-> (link_on && !acc_off)); // R7
   AST_BLANK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      blank_busy |-> (!link_on && !accel_en)); // R8
   AST_FRESH_AFTER_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(blank_busy) |-> (qual == '0)); // R9
endmodule

// File: tb/i2c_join_seq_bench.sv
`timescale 1ns/1ps
module i2c_join_seq_bench;
   localparam int unsigned IDLE  = 40;
   localparam int unsigned BLANK = 100;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic pwr_good = 1'b0, enable = 1'b1, acc_off = 1'b0, out_supply_hi = 1'b0;
   logic a_sda = 1'b1, a_scl = 1'b1, b_sda = 1'b1, b_scl = 1'b1;
   logic link_on, ready, precharge_en, accel_en;

   int checks = 0;
   int fails  = 0;

   always #4 clk = ~clk;

   i2c_join_seq #(.IDLE_CYCLES(IDLE), .BLANK_CYCLES(BLANK), .SYNC_STAGES(2)) u_i2c_join_seq (
      .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .enable(enable),
      .acc_off(acc_off), .out_supply_hi(out_supply_hi),
      .a_sda(a_sda), .a_scl(a_scl), .b_sda(b_sda), .b_scl(b_scl),
      .link_on(link_on), .ready(ready), .precharge_en(precharge_en), .accel_en(accel_en)
   );

   // mode: 0 lockout, 1 watching, 2 joined, 3 blanking
   // vector order {link_on, ready, precharge_en, accel_en}
   function automatic logic [3:0] expv(int mode, logic aoff);
      case (mode)
         0, 1:    return 4'b0010;
         2:       return {3'b110, !aoff};
         default: return 4'b0000;
      endcase
   endfunction

   // a side is free after the sequence if it saw a STOP, or if it sat idle long enough
   function automatic logic exp_join(int act_a, int act_b, logic long_wait);
      logic fa, fb;
      fa = (act_a == 1) || (act_a == 2 && long_wait);
      fb = (act_b == 1) || (act_b == 2 && long_wait);
      return fa && fb;
   endfunction

   task automatic step(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(string tag, logic [3:0] exp);
      logic [3:0] act;
      act = {link_on, ready, precharge_en, accel_en};
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%b expected=%b", tag, act, exp);
      end
   endtask

   task automatic set_side(int side, logic sda, logic scl);
      if (side == 0) begin a_sda = sda; a_scl = scl; end
      else           begin b_sda = sda; b_scl = scl; end
   endtask

   task automatic do_stop(int side);
      set_side(side, 1'b1, 1'b0); step(3);
      set_side(side, 1'b0, 1'b0); step(3);
      set_side(side, 1'b0, 1'b1); step(3);
      set_side(side, 1'b1, 1'b1); step(3);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      step(3);
      rst_n = 1'b1;
      step(5);
      chk("R1 reset lockout", expv(0, 1'b0));
      step(IDLE + 30);
      chk("R1 idle bus ignored in lockout", expv(0, 1'b0));

      // supply good but disabled
      enable = 1'b0;
      pwr_good = 1'b1;
      step(IDLE + 30);
      chk("R2 no join while disabled", expv(1, 1'b0));

      // both sides busy, then STOP on A only
      set_side(0, 1'b1, 1'b0);
      set_side(1, 1'b1, 1'b0);
      enable = 1'b1;
      step(5);
      do_stop(0);
      step(10);
      chk("R5 STOP on one side only", expv(1, 1'b0));
      step(IDLE + 10);
      chk("R5 A free, B busy", expv(1, 1'b0));

      // B released with SDA and SCL together: not a STOP, idle must elapse
      set_side(1, 1'b1, 1'b1);
      step(10);
      chk("R3 joint rise is not STOP", expv(1, 1'b0));
      step(IDLE - 16);
      chk("R4 before idle time", expv(1, 1'b0));
      step(20);
      chk("R5 mix STOP and idle joins", expv(2, 1'b0));
      chk("R6 join outputs", expv(2, 1'b0));

      acc_off = 1'b1;
      step(1);
      chk("R7 acc_off gates accelerators", expv(2, 1'b1));
      acc_off = 1'b0;
      step(1);
      chk("R7 accelerators back", expv(2, 1'b0));

      // disable drops the join, re-enable needs a new idle run
      enable = 1'b0;
      step(2);
      chk("R2 disable drops join", expv(1, 1'b0));
      enable = 1'b1;
      step(10);
      chk("R2 old qualification discarded", expv(1, 1'b0));
      step(IDLE + 5);
      chk("R4 idle on both sides joins", expv(2, 1'b0));

      // rising supply crossing
      out_supply_hi = 1'b1;
      step(4);
      chk("R8 rising crossing drops join", expv(3, 1'b0));
      step(20);
      set_side(0, 1'b1, 1'b0); set_side(1, 1'b1, 1'b0);
      step(3);
      do_stop(0);
      do_stop(1);
      step(BLANK - 60);
      chk("R8 STOPs ignored in blanking", expv(3, 1'b0));
      step(IDLE - 5);
      chk("R9 fresh idle needed after blank", expv(1, 1'b0));
      step(20);
      chk("R9 rejoin after blank and idle", expv(2, 1'b0));

      // falling crossing, then a second crossing restarts the window
      out_supply_hi = 1'b0;
      step(50);
      out_supply_hi = 1'b1;
      step(BLANK - 20);
      chk("R8 restart keeps blanking", expv(3, 1'b0));
      step(IDLE + 35);
      chk("R8 rejoin after restarted window", expv(2, 1'b0));

      // supply loss while joined
      pwr_good = 1'b0;
      step(2);
      chk("R1 supply loss forces lockout", expv(0, 1'b0));
      pwr_good = 1'b1;
      step(IDLE + 10);
      chk("R1 recovery from lockout", expv(2, 1'b0));

      // random patterns: 0 busy, 1 STOP, 2 go idle
      for (int it = 0; it < 30; it++) begin
         int act_a, act_b;
         logic aoff;
         act_a = int'($urandom_range(2, 0));
         act_b = int'($urandom_range(2, 0));
         aoff  = logic'($urandom_range(1, 0));
         set_side(0, 1'b1, 1'b0); set_side(1, 1'b1, 1'b0);
         enable = 1'b0;
         step(3);
         enable = 1'b1;
         acc_off = aoff;
         step(3);
         chk("R2 cleared before pattern", expv(1, aoff));
         if (act_a == 1) do_stop(0);
         if (act_b == 1) do_stop(1);
         if (act_a == 2) set_side(0, 1'b1, 1'b1);
         if (act_b == 2) set_side(1, 1'b1, 1'b1);
         step(8);
         chk("R5 random short wait", expv(exp_join(act_a, act_b, 1'b0) ? 2 : 1, aoff));
         step(IDLE + 10);
         chk("R4 random long wait", expv(exp_join(act_a, act_b, 1'b1) ? 2 : 1, aoff));
      end

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule